// File: doc/BRIEF.md
# Interrupt Test Peripheral

This block is a small register-mapped peripheral that exercises one interrupt path of a larger chip. Software reaches it through a 32-bit word-access bus port: it can raise the single interrupt source on purpose, clear it, and open or close the gate that lets it through. An external level input also drives the same pending bit, so hardware and software can both provoke the source. One pending signal feeds two outputs, an interrupt line and a wake line. Both are high only while the source is pending and not masked.

The mask cannot be written directly. It opens through a write to the enable command word and closes through a write to the disable command word, and it starts closed after reset. The block also carries a 32-bit scratch data word, a config word with no implemented bits, and a status word that shows two external power-state inputs.

The bus port uses a byte address. Bits [1:0] of the address are ignored and the rest select a word. Reads are combinational and return the selected word in the same cycle in which the port is enabled with the write flag low. At all other times they return 0. Writes take effect at the clock edge. The external inputs are assumed to be synchronous to the clock.

Top module: `irq_probe_periph`

## Requirements
- R1: After a synchronous reset, both outputs are 0, the mask word (byte 0x14) reads 0x1, the pending word (byte 0x10) reads 0 and the data word (byte 0x08) reads 0. Both outputs are held at 0 while reset is high.
- R2: The interrupt and wake outputs are equal. At every clock edge each output takes the value that pending bit 0 AND NOT mask bit 0 had before that edge, so the outputs change one edge after the state changes.
- R3: A write to byte 0x10 with bit 0 set clears the pending bit, and with bit 0 clear it leaves the pending bit alone. Bits 31:1 of that word always read 0.
- R4: A bus write to the mask word at byte 0x14 has no effect on the mask.
- R5: A write to byte 0x18 with bit 0 set clears mask bit 0, and a write to byte 0x1C with bit 0 set sets it. A write with bit 0 clear changes nothing. Both command words read 0.
- R6: A write to byte 0x20 with bit 0 set sets the pending bit. This command word reads 0.
- R7: When the external interrupt level differs from the level sampled at the previous edge, the pending bit takes the new level. The sampled level resets to 0. A level that stays steady does not rewrite the pending bit.
- R8: When an external level change falls in the same cycle as a clear write or a trigger write, the external level decides the pending bit.
- R9: The status word at byte 0x04 reads the power input in bit 0 and the halt input in bit 1, with 0 in the other bits. Writes to it are ignored.
- R10: The config word at byte 0x00 reads 0 and ignores writes. The data word at byte 0x08 stores and returns all 32 bits.
- R11: Words with no register (byte 0x0C, and 0x24 upward) read 0 and ignore writes. Address bits [1:0] do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| ext_irq_in | input | 1 | External level-sensitive interrupt source |
| pwr_on_in | input | 1 | External power-state input |
| halt_in | input | 1 | External halt-state input |
| irq_out | output | 1 | Interrupt line |
| wake_out | output | 1 | Wake line |

## Verification
The bus port carries one access per cycle, so the only two functions that can land on the pending bit in the same cycle are a software command (a clear or a trigger) and a change of the external level. The bench provokes this by driving the bus write and flipping the external input at the same falling edge. One case is a clear paired with a rising level, with the bit already set by a trigger. The other is a trigger paired with a falling level. It then reads the pending word after the next edge and expects the new external level in both cases.

// File: rtl/irq_probe_pkg.sv
package irq_probe_pkg;

    // Word indices (byte offset / 4) of the register window
    localparam int unsigned WORD_CFG   = 0;
    localparam int unsigned WORD_STAT  = 1;
    localparam int unsigned WORD_DATA  = 2;
    localparam int unsigned WORD_PEND  = 4;
    localparam int unsigned WORD_MASK  = 5;
    localparam int unsigned WORD_OPEN  = 6;
    localparam int unsigned WORD_SHUT  = 7;
    localparam int unsigned WORD_RAISE = 8;

    // What a read returns
    typedef enum logic [2:0] {
        RSEL_ZERO,
        RSEL_STAT,
        RSEL_DATA,
        RSEL_PEND,
        RSEL_MASK
    } rsel_e;

    // Write-side commands, one per cycle at most
    typedef struct packed {
        logic clr_pend;
        logic set_pend;
        logic open_mask;
        logic shut_mask;
        logic data_we;
    } cmd_t;

    // Interrupt state held by the core
    typedef struct packed {
        logic pend;
        logic mask;
    } irq_state_t;

    localparam irq_state_t IRQ_STATE_RST = '{pend: 1'b0, mask: 1'b1};

    function automatic rsel_e word_to_rsel(input logic [31:0] word);
        rsel_e r;
        case (word)
            WORD_STAT: r = RSEL_STAT;
            WORD_DATA: r = RSEL_DATA;
            WORD_PEND: r = RSEL_PEND;
            WORD_MASK: r = RSEL_MASK;
            default:   r = RSEL_ZERO;
        endcase
        return r;
    endfunction

    function automatic cmd_t word_to_cmd(input logic [31:0] word, input logic bit0);
        cmd_t c;
        c = '0;
        case (word)
            WORD_PEND:  c.clr_pend  = bit0;
            WORD_RAISE: c.set_pend  = bit0;
            WORD_OPEN:  c.open_mask = bit0;
            WORD_SHUT:  c.shut_mask = bit0;
            WORD_DATA:  c.data_we   = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_probe_decode.sv
module irq_probe_decode
    import irq_probe_pkg::*;
#(
    parameter int unsigned WORD_W = 6
) (
    input  logic              en,
    input  logic              we,
    input  logic [WORD_W-1:0] word,
    input  logic              wbit0,
    output cmd_t              cmd,
    output rsel_e             rsel
);
    logic [31:0] word32;

    always_comb begin
        word32 = 32'(word);
        cmd    = '0;
        rsel   = RSEL_ZERO;
        if (en && we) begin
            cmd = word_to_cmd(word32, wbit0);
        end
        if (en && !we) begin
            rsel = word_to_rsel(word32);
        end
    end
endmodule

// File: rtl/irq_probe_core.sv
module irq_probe_core
    import irq_probe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic ext_irq,
    output logic pend,
    output logic mask,
    output logic irq_o,
    output logic wake_o
);
    irq_state_t st_q, st_d;
    logic       ext_prev_q;
    logic       ext_chg;

    assign ext_chg = ext_irq ^ ext_prev_q;

    always_comb begin
        st_d = st_q;
        // software clear, then software set, then the external level last
        if (cmd.clr_pend)  st_d.pend = 1'b0;
        if (cmd.set_pend)  st_d.pend = 1'b1;
        if (ext_chg)       st_d.pend = ext_irq;
        if (cmd.open_mask) st_d.mask = 1'b0;
        if (cmd.shut_mask) st_d.mask = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= IRQ_STATE_RST;
            ext_prev_q <= 1'b0;
            irq_o      <= 1'b0;
            wake_o     <= 1'b0;
        end else begin
            st_q       <= st_d;
            ext_prev_q <= ext_irq;
            irq_o      <= st_q.pend & ~st_q.mask;
            wake_o     <= st_q.pend & ~st_q.mask;
        end
    end

    assign pend = st_q.pend;
    assign mask = st_q.mask;

    a_r2_outputs_follow_state: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(pend && !mask)) && (wake_o == irq_o));

    a_r4_mask_holds_without_command: assert property (@(posedge clk) disable iff (rst)
        (!cmd.open_mask && !cmd.shut_mask) |=> $stable(mask));

    a_r5_open_clears_mask: assert property (@(posedge clk) disable iff (rst)
        cmd.open_mask |=> !mask);

    a_r5_shut_sets_mask: assert property (@(posedge clk) disable iff (rst)
        cmd.shut_mask |=> mask);

    a_r6_raise_sets_pending: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_pend && !ext_chg) |=> pend);

    a_r3_clear_drops_pending: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_pend && !cmd.set_pend && !ext_chg) |=> !pend);

    a_r7_level_change_overwrites: assert property (@(posedge clk) disable iff (rst)
        ext_chg |=> pend == $past(ext_irq));
endmodule

// File: rtl/irq_probe_scratch.sv
module irq_probe_scratch #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    a_r10_scratch_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/irq_probe_readmux.sv
module irq_probe_readmux
    import irq_probe_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  rsel_e             rsel,
    input  logic [DATA_W-1:0] data,
    input  logic              pend,
    input  logic              mask,
    input  logic              pwr_on,
    input  logic              halt,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (rsel)
            RSEL_STAT: rdata = DATA_W'({halt, pwr_on});
            RSEL_DATA: rdata = data;
            RSEL_PEND: rdata = DATA_W'(pend);
            RSEL_MASK: rdata = DATA_W'(mask);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_probe_periph.sv
module irq_probe_periph
    import irq_probe_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_irq_in,
    input  logic              pwr_on_in,
    input  logic              halt_in,
    output logic              irq_out,
    output logic              wake_out
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    cmd_t              cmd;
    rsel_e             rsel;
    logic              pend;
    logic              mask;
    logic [DATA_W-1:0] scratch_q;
    logic              unused_byte_lanes;

    assign unused_byte_lanes = ^bus_addr[1:0];

    irq_probe_decode #(.WORD_W(WORD_W)) u_decode (
        .en    (bus_en),
        .we    (bus_we),
        .word  (bus_addr[ADDR_W-1:2]),
        .wbit0 (bus_wdata[0]),
        .cmd   (cmd),
        .rsel  (rsel)
    );

    irq_probe_core u_core (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .ext_irq (ext_irq_in),
        .pend    (pend),
        .mask    (mask),
        .irq_o   (irq_out),
        .wake_o  (wake_out)
    );

    irq_probe_scratch #(.DATA_W(DATA_W)) u_scratch (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd.data_we),
        .wdata (bus_wdata),
        .q     (scratch_q)
    );

    irq_probe_readmux #(.DATA_W(DATA_W)) u_readmux (
        .rsel   (rsel),
        .data   (scratch_q),
        .pend   (pend),
        .mask   (mask),
        .pwr_on (pwr_on_in),
        .halt   (halt_in),
        .rdata  (bus_rdata)
    );

    a_r11_idle_bus_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> bus_rdata == '0);
endmodule

// File: tb/irq_probe_periph_tb.sv
module irq_probe_periph_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_irq_in = 1'b0;
    logic        pwr_on_in = 1'b0;
    logic        halt_in = 1'b0;
    logic        irq_out;
    logic        wake_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    irq_probe_periph u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_irq_in(ext_irq_in), .pwr_on_in(pwr_on_in), .halt_in(halt_in),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge; state updates at the next rising edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic expect_read(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic expect_outs(input string req, input logic exp);
        check({req, " irq"}, {31'b0, irq_out}, {31'b0, exp});
        check({req, " wake"}, {31'b0, wake_out}, {31'b0, exp});
    endtask

    task automatic test_reset();
        @(negedge clk);
        expect_outs("R1 during reset", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_outs("R1 after reset", 1'b0);
        expect_read("R1 mask", 8'h14, 32'h1);
        expect_read("R1 pending", 8'h10, 32'h0);
        expect_read("R1 data", 8'h08, 32'h0);
    endtask

    task automatic test_data_cfg();
        bus_write(8'h08, 32'hA5C3_5A3C);
        expect_read("R10 data store", 8'h08, 32'hA5C3_5A3C);
        bus_write(8'h00, 32'hFFFF_FFFF);
        expect_read("R10 config reads zero", 8'h00, 32'h0);
        expect_read("R10 data kept after config write", 8'h08, 32'hA5C3_5A3C);
    endtask

    task automatic test_status();
        pwr_on_in = 1'b1; halt_in = 1'b0;
        expect_read("R9 power bit", 8'h04, 32'h1);
        halt_in = 1'b1;
        expect_read("R9 both bits", 8'h04, 32'h3);
        pwr_on_in = 1'b0;
        expect_read("R9 halt bit", 8'h04, 32'h2);
        bus_write(8'h04, 32'hFFFF_FFFF);
        expect_read("R9 write ignored", 8'h04, 32'h2);
    endtask

    task automatic test_mask_cmds();
        bus_write(8'h14, 32'h0);
        expect_read("R4 mask write ignored", 8'h14, 32'h1);
        bus_write(8'h18, 32'hFFFF_FFFE);
        expect_read("R5 open with bit0 clear", 8'h14, 32'h1);
        bus_write(8'h18, 32'h1);
        expect_read("R5 open clears mask", 8'h14, 32'h0);
        expect_read("R5 open word reads zero", 8'h18, 32'h0);
        bus_write(8'h14, 32'h1);
        expect_read("R4 mask write ignored when open", 8'h14, 32'h0);
        bus_write(8'h1C, 32'h1);
        expect_read("R5 shut sets mask", 8'h14, 32'h1);
        expect_read("R5 shut word reads zero", 8'h1C, 32'h0);
    endtask

    task automatic test_raise_clear();
        bus_write(8'h20, 32'hFFFF_FFFF);
        expect_read("R6 raise sets pending, R3 upper bits zero", 8'h10, 32'h1);
        expect_read("R6 raise word reads zero", 8'h20, 32'h0);
        expect_outs("R2 masked pending stays low", 1'b0);
        bus_write(8'h18, 32'h1);
        expect_outs("R2 no change before next edge", 1'b0);
        @(negedge clk);
        expect_outs("R2 unmasked pending drives outputs", 1'b1);
        bus_write(8'h10, 32'hFFFF_FFFE);
        expect_read("R3 clear with bit0 clear", 8'h10, 32'h1);
        bus_write(8'h10, 32'h1);
        expect_read("R3 clear drops pending", 8'h10, 32'h0);
        @(negedge clk);
        expect_outs("R2 outputs drop after clear", 1'b0);
    endtask

    task automatic test_ext_level();
        @(negedge clk);
        ext_irq_in = 1'b1;
        @(negedge clk);
        expect_read("R7 rising level sets pending", 8'h10, 32'h1);
        expect_outs("R2 outputs follow external", 1'b1);
        bus_write(8'h10, 32'h1);
        repeat (2) @(negedge clk);
        expect_read("R7 steady level does not rewrite", 8'h10, 32'h0);
        bus_write(8'h20, 32'h1);
        @(negedge clk);
        ext_irq_in = 1'b0;
        @(negedge clk);
        expect_read("R7 falling level clears pending", 8'h10, 32'h0);
    endtask

    task automatic test_collision();
        bus_write(8'h20, 32'h1);
        expect_read("R8 setup pending", 8'h10, 32'h1);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1;
        ext_irq_in = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        expect_read("R8 rising level beats clear", 8'h10, 32'h1);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
        ext_irq_in = 1'b0;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        expect_read("R8 falling level beats raise", 8'h10, 32'h0);
    endtask

    task automatic test_unmapped();
        bus_write(8'h0C, 32'hFFFF_FFFF);
        expect_read("R11 hole reads zero", 8'h0C, 32'h0);
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        expect_read("R11 beyond window reads zero", 8'h24, 32'h0);
        expect_read("R11 data untouched", 8'h08, 32'hA5C3_5A3C);
        expect_read("R11 pending untouched", 8'h10, 32'h0);
        expect_read("R11 mask untouched", 8'h14, 32'h0);
        expect_read("R11 low address bits ignored", 8'h0B, 32'hA5C3_5A3C);
    endtask

    initial begin
        test_reset();
        test_data_cfg();
        test_status();
        test_mask_cmds();
        test_raise_clear();
        test_ext_level();
        test_collision();
        test_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule